// File: doc/BRIEF.md
# Sampling Clock Ratio Monitor

This monitor watches a slow sampling clock from inside the faster bus clock domain and reports when that clock has become too slow. The sampling clock passes through a flop synchroniser. Its rising edges are found by comparing successive synchronised samples. A saturating counter measures the number of bus-clock cycles between consecutive edges. When that gap reaches the configured ratio (16 by default), the sampling clock is no faster than the bus clock divided by the ratio, and the monitor reports a fault.

Two indications come out of the block. The first is a live error status that clears by itself once the sampling clock is healthy again. The second is a sticky error flag that software must clear. A one-cycle pulse marks the cycle in which the live status rises, and that pulse is what sets the sticky flag. The monitor runs only while its detect-disable input is 0. While that input is 1, the gap counter is held at zero and the live status is forced low.

Top module: `clk_ratio_monitor`

## Requirements
- R1: While `rst_n` is sampled low at a bus clock edge, `err_live`, `err_flag` and `err_rise` are 0 after that edge.
- R2: While `det_disable` is 1, `err_live` and `err_rise` stay 0 whatever the sampling clock does, including when it is stopped.
- R3: With `det_disable` at 0 and a steady sampling clock whose period is below RATIO bus cycles, `err_live` stays 0.
- R4: With `det_disable` at 0 and a steady sampling clock whose period is RATIO bus cycles or more, `err_live` stays 1.
- R5: After the monitor is enabled with the sampling clock low, and a single rising edge is then presented with no further edge, `err_live` first reads 1 after bus edge RATIO+SYNC_STAGES+1. Bus edges are counted from the first edge after the change.
- R6: Once set, `err_live` clears only after a detected edge that ends a gap shorter than RATIO cycles. The first edge that follows a long gap leaves it at 1.
- R7: `err_rise` is 1 for exactly one cycle: the first cycle in which `err_live` is 1. It pulses once per error episode.
- R8: `err_flag` becomes 1 on the bus edge after the `err_rise` pulse. It then holds until a bus edge where `flag_clear` is 1 and no `err_rise` pulse is present. When both are present at the same edge, setting wins.
- R9: Raising `det_disable` forces `err_live` to 0 at the next bus edge and leaves `err_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_clk | input | 1 | Sampling clock, asynchronous to `clk` |
| det_disable | input | 1 | 1 turns the monitor off, 0 turns it on |
| flag_clear | input | 1 | Clears the sticky flag |
| err_live | output | 1 | Live clock-too-slow status, self-clearing |
| err_flag | output | 1 | Sticky clock-error flag |
| err_rise | output | 1 | One-cycle pulse when `err_live` rises |

## Verification
The bench builds the monitor with RATIO=16 and SYNC_STAGES=2. With these values it can sweep every sampling period from 2 to 24 bus cycles in both rising and falling order, so both sides of the 15/16 boundary and the clearing path are covered. The small synchroniser depth makes the detection latency an exact cycle count of 19. That allows the rise pulse, the set-over-clear priority of the flag, and the single-edge case that must not clear to be checked against a precise cycle.

// File: rtl/clk_ratio_pkg.sv
// Package: shared sizing helpers for the sampling clock ratio monitor.
// Assumes ratios are small positive integers.
package clk_ratio_pkg;

    // Width needed for a counter that saturates at the given ratio.
    function automatic int gap_cnt_width(input int ratio);
        return $clog2(ratio + 1);
    endfunction

endpackage

// File: rtl/ratio_edge_sync.sv
// Module: synchronises an asynchronous clock into the local domain and emits
// a one-cycle pulse for each rising edge seen after the synchroniser.
// Assumes the input is at most half the local clock rate, so no edge is lost.
module ratio_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    // Synchroniser stages plus one history flop for edge detection.
    logic [SYNC_STAGES:0] stg;

    generate
        for (genvar i = 0; i <= SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage captures the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= 1'b0;
                    else        stg[0] <= async_in;
                end
            end else begin : g_next
                // Later stages shift the sample down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[i] <= 1'b0;
                    else        stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    // A rising edge is present when the newest settled sample is 1 and the one before it was 0.
    assign rise_pulse = stg[SYNC_STAGES-1] & ~stg[SYNC_STAGES];

endmodule

// File: rtl/ratio_gap_counter.sv
// Module: counts local cycles between detected edges and keeps the live
// too-slow status plus its rising-edge pulse.
// Assumes edge_seen is a single-cycle pulse per sampling edge.
module ratio_gap_counter #(
    parameter int RATIO = 16,
    parameter int CNT_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic edge_seen,
    output logic live,
    output logic rise
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RATIO);

    logic [CNT_W-1:0] gap_cnt;
    logic             at_limit;

    assign at_limit = (gap_cnt == LIMIT);

    // Gap counter: restarts at 1 on each edge, saturates at the limit, held at 0 while off.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) gap_cnt <= '0;
        else if (edge_seen)    gap_cnt <= CNT_W'(1);
        else if (!at_limit)    gap_cnt <= gap_cnt + CNT_W'(1);
    end

    // Live status: set when the gap reaches the limit, cleared by an edge ending a short gap.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) live <= 1'b0;
        else if (at_limit)     live <= 1'b1;
        else if (edge_seen)    live <= 1'b0;
    end

    // Rise pulse: high in the first cycle the live status reads 1.
    always_ff @(posedge clk) begin
        if (!rst_n) rise <= 1'b0;
        else        rise <= enable && at_limit && !live;
    end

endmodule

// File: rtl/ratio_sticky_flag.sv
// Module: sticky flag set by a pulse and cleared by request; set has priority.
// Assumes the clear request is level or pulse in the local domain.
module ratio_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_pulse,
    input  logic clear_req,
    output logic flag
);
    // Flag register: setting wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag <= 1'b0;
        else if (set_pulse) flag <= 1'b1;
        else if (clear_req) flag <= 1'b0;
    end

endmodule

// File: rtl/clk_ratio_monitor.sv
// Module: top of the sampling clock ratio monitor. It flags when the sampling
// clock period reaches RATIO bus cycles or more.
// Assumes samp_clk is asynchronous to clk, SYNC_STAGES >= 2 and RATIO >= 2.
module clk_ratio_monitor #(
    parameter int RATIO       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_clk,
    input  logic det_disable,
    input  logic flag_clear,
    output logic err_live,
    output logic err_flag,
    output logic err_rise
);
    import clk_ratio_pkg::*;

    localparam int CNT_W = gap_cnt_width(RATIO);

    logic samp_edge;
    logic mon_enable;

    assign mon_enable = ~det_disable;

    ratio_edge_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (samp_clk),
        .rise_pulse (samp_edge)
    );

    ratio_gap_counter #(
        .RATIO (RATIO),
        .CNT_W (CNT_W)
    ) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (mon_enable),
        .edge_seen (samp_edge),
        .live      (err_live),
        .rise      (err_rise)
    );

    ratio_sticky_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (err_rise),
        .clear_req (flag_clear),
        .flag      (err_flag)
    );

endmodule

// File: rtl/clk_ratio_monitor_chk.sv
// Module: property checker for the sampling clock ratio monitor.
// Attached to every instance of the top through the bind below.
module clk_ratio_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic det_disable,
    input logic flag_clear,
    input logic samp_edge,
    input logic err_live,
    input logic err_flag,
    input logic err_rise
);
    // R1: reset leaves every output low.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!err_live && !err_flag && !err_rise));

    // R9: the monitor being off forces the live status low one edge later.
    assert_disable_forces_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        det_disable |=> !err_live);

    // R2: no rise pulse while off.
    assert_no_pulse_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        det_disable |=> !err_rise);

    // R6: while enabled, live status falls only after a detected edge.
    assert_clear_needs_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(err_live) && !$past(det_disable)) |-> $past(samp_edge));

    // R7: every rise of the live status carries the pulse.
    assert_rise_marks_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_live) |-> err_rise);

    // R7: pulse only together with live status, one cycle long.
    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_rise |-> (err_live && !$past(err_live)));

    // R8: pulse sets the sticky flag.
    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_rise |=> err_flag);

    // R8: flag holds without a clear request.
    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !flag_clear) |=> err_flag);

endmodule

bind clk_ratio_monitor clk_ratio_monitor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .det_disable (det_disable),
    .flag_clear  (flag_clear),
    .samp_edge   (samp_edge),
    .err_live    (err_live),
    .err_flag    (err_flag),
    .err_rise    (err_rise)
);

// File: tb/tb_clk_ratio_monitor.sv
// Bench: period sweeps and directed cycle-exact checks for the ratio monitor.
module tb_clk_ratio_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int RATIO      = 16;
    localparam int SYNC       = 2;
    localparam int LAT        = RATIO + SYNC + 1;

    logic clk = 1'b0;
    logic rst_n;
    logic samp_clk;
    logic det_disable;
    logic flag_clear;
    logic err_live;
    logic err_flag;
    logic err_rise;

    int n_checks = 0;
    int n_fail   = 0;
    int mism;
    int rises;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_ratio_monitor #(.RATIO(RATIO), .SYNC_STAGES(SYNC)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .samp_clk    (samp_clk),
        .det_disable (det_disable),
        .flag_clear  (flag_clear),
        .err_live    (err_live),
        .err_flag    (err_flag),
        .err_rise    (err_rise)
    );

    // Record one check; a failing one prints a single FAIL line.
    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // One sampling period of p bus cycles; samples before driving at each negedge.
    task automatic drive_period(input int p, input bit do_chk, input bit exp_live);
        for (int c = 0; c < p; c++) begin
            @(negedge clk);
            if (do_chk && (err_live !== exp_live)) mism++;
            if (err_rise === 1'b1) rises++;
            samp_clk = (c < p/2);
        end
    endtask

    // Hold the sampling clock at a level for n cycles, counting pulses and live readings.
    task automatic hold_level(input bit lvl, input int n, input bit exp_live);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            if (err_live !== exp_live) mism++;
            if (err_rise === 1'b1) rises++;
            samp_clk = lvl;
        end
    endtask

    task automatic sweep_point(input int p);
        mism = 0;
        repeat (8) drive_period(p, 1'b0, 1'b0);
        repeat (3) drive_period(p, 1'b1, p >= RATIO);
        if (p >= RATIO) check(mism == 0, $sformatf("R4 period %0d", p), mism, 0);
        else            check(mism == 0, $sformatf("R3/R6 period %0d", p), mism, 0);
    endtask

    initial begin
        rst_n = 1'b0; samp_clk = 1'b0; det_disable = 1'b0; flag_clear = 1'b0;
        repeat (3) @(negedge clk);
        check(err_live === 1'b0, "R1 live", int'(err_live), 0);
        check(err_flag === 1'b0, "R1 flag", int'(err_flag), 0);
        check(err_rise === 1'b0, "R1 rise", int'(err_rise), 0);
        rst_n = 1'b1;

        // Ascending sweep: the error appears at the threshold and persists (R3, R4, R7).
        rises = 0;
        for (int p = 2; p <= 24; p++) sweep_point(p);
        check(rises == 1, "R7 one pulse on ascending sweep", rises, 1);
        check(err_flag === 1'b1, "R8 flag after error", int'(err_flag), 1);

        // Descending sweep: the status clears below the threshold with no new pulse (R6, R7).
        rises = 0;
        for (int p = 24; p >= 2; p--) sweep_point(p);
        check(rises == 0, "R7 no pulse on descending sweep", rises, 0);
        check(err_flag === 1'b1, "R8 flag held", int'(err_flag), 1);

        // Clear request drops the flag (R8).
        @(negedge clk); flag_clear = 1'b1; samp_clk = 1'b0;
        @(negedge clk); flag_clear = 1'b0;
        check(err_flag === 1'b0, "R8 flag cleared", int'(err_flag), 0);

        // Stopped clock produces an error; then turning off forces live low, flag kept (R9).
        repeat (LAT + 6) @(negedge clk);
        check(err_live === 1'b1, "R4 stopped clock", int'(err_live), 1);
        det_disable = 1'b1;
        @(negedge clk);
        check(err_live === 1'b0, "R9 live forced low", int'(err_live), 0);
        check(err_flag === 1'b1, "R9 flag unchanged", int'(err_flag), 1);

        // Off with a stopped clock: nothing reported (R2).
        mism = 0; rises = 0;
        hold_level(1'b0, 60, 1'b0);
        check(mism == 0, "R2 live stays low while off", mism, 0);
        check(rises == 0, "R2 no pulse while off", rises, 0);
        flag_clear = 1'b1;
        @(negedge clk);
        check(err_flag === 1'b0, "R8 flag cleared while off", int'(err_flag), 0);

        // Exact latency with a single edge, clear request held high (R5, R7, R8).
        det_disable = 1'b0; samp_clk = 1'b1;
        for (int k = 1; k <= LAT + 3; k++) begin
            @(negedge clk);
            check(err_live === (k >= LAT), $sformatf("R5 live at edge %0d", k),
                  int'(err_live), int'(k >= LAT));
            check(err_rise === (k == LAT), $sformatf("R7 pulse at edge %0d", k),
                  int'(err_rise), int'(k == LAT));
            check(err_flag === (k == LAT + 1), $sformatf("R8 set wins at edge %0d", k),
                  int'(err_flag), int'(k == LAT + 1));
            if (k == 4) samp_clk = 1'b0;
        end
        flag_clear = 1'b0;

        // A single edge after a long gap must not clear; a second close edge must (R6).
        samp_clk = 1'b1;
        repeat (2) @(negedge clk);
        samp_clk = 1'b0;
        repeat (6) @(negedge clk);
        check(err_live === 1'b1, "R6 first edge keeps status", int'(err_live), 1);
        samp_clk = 1'b1;
        repeat (2) @(negedge clk);
        samp_clk = 1'b0;
        repeat (3) @(negedge clk);
        check(err_live === 1'b0, "R6 short gap clears status", int'(err_live), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule